// File: doc/BRIEF.md
# SPI Register Message Layer

This block sits above a byte-level SPI slave and turns its stream of bytes into register-access messages. It holds a bank of 32-bit registers. The lower part of the bank is read-write: the SPI master sets those registers and the fabric sees them on an output vector. The upper part is read-only: fabric logic drives it, and the master can only read it.

Each message begins with a command byte. Bit 7 selects a write (1) or a read (0), and bits 6:0 select the register index. The block answers the command with a status byte. A 32-bit register value then follows as four bytes, most significant byte first. On a read the block loads those bytes for transmission. On a write it collects them from the master and stores the word only after the last byte has arrived.

A four-state machine and a byte counter frame each message. Dropping slave select returns the machine to its idle state at any point in a message.

Top module: `spi_msg_regbank`

## Requirements
- R1: After reset, msg_state_o is 0, tx_load_o is low and every read-write register holds zero.
- R2: A byte accepted in idle (sel_i high) is a command. One cycle after its strobe, tx_load_o pulses with a status byte. The status byte has bits [7:4]=1010, bits [3:2]=00, bit 1 equal to the command's write flag and bit 0 set when the command's index is illegal. The state becomes 1.
- R3: In a read (command bit 7 = 0, bits 6:0 = index), the next strobe moves the state to 2 and loads byte 3 (bits 31:24) of the word. Each of the next three strobes loads the next lower byte. The fourth strobe in state 2 returns to idle and loads nothing.
- R4: A read returns the register value as sampled at the strobe that follows the command. Later changes of ro_regs_i do not alter the bytes still to be sent.
- R5: In a write, the next strobe moves the state to 3. The next four bytes form the word, most significant byte first. The register changes only at the fourth of those bytes, to the assembled word. No byte is loaded for transmission while the state is 3.
- R6: A write to an index of N_RW or more is dropped, and its status sets bit 0. A read from an index of N_RW+N_RO or more sets status bit 0 and returns four zero bytes. Reads of read-only indices report no error.
- R7: While sel_i is low, the state returns to 0 and the byte counter clears. A write that is cut short leaves its register unchanged, and the first byte after reselection is treated as a command.
- R8: Strobes on rx_valid_i while sel_i is low cause no load and no state change.
- R9: Register n occupies bits 32n+31:32n of rw_regs_o. Read-only index N_RW+k reads bits 32k+31:32k of ro_regs_i.
- R10: msg_state_o encodes the states as 0 idle, 1 send status, 2 send word, 3 receive word. The byte counter is zero whenever the state is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Slave select, high while a message is in progress |
| rx_valid_i | input | 1 | One-cycle strobe: a byte has been received |
| rx_byte_i | input | 8 | Received byte |
| tx_load_o | output | 1 | One-cycle strobe: load tx_byte_o for the next transfer |
| tx_byte_o | output | 8 | Byte to transmit next |
| msg_state_o | output | 2 | Current message state code |
| rw_regs_o | output | 32*N_RW | Read-write registers, flattened |
| ro_regs_i | input | 32*N_RO | Read-only registers from fabric, flattened |

## Verification
The bench attacks the word boundaries. It checks that a write stays invisible after three of its four bytes, which a design that commits byte by byte would fail. It checks that a read keeps sending the sampled word after ro_regs_i changes, which a design that reads the live input at every byte would fail. It also covers illegal indices: a read-only or out-of-range write that lands anyway, or a missing error bit, shows up in the register vector or in the status byte. Finally, slave select is dropped in the middle of a write and strobes are sent while deselected. A machine that resumes the old message would then misread the next command, and the scoreboard flags any load it did not expect.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BIDX_W     = $clog2(WORD_BYTES);
  localparam int ADDR_W     = 7;
  localparam logic [3:0] STAT_TAG = 4'hA;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TX_STAT = 2'd1,
    ST_TX_WORD = 2'd2,
    ST_RX_WORD = 2'd3
  } msg_state_e;

  // Status answer: tag nibble, two zero bits, write flag, error flag.
  function automatic logic [7:0] status_byte(input logic wr, input logic err);
    return {STAT_TAG, 2'b00, wr, err};
  endfunction

  // Byte k of a word, k = 0 is the least significant byte.
  function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w,
                                           input logic [BIDX_W-1:0] k);
    return w[8*k +: 8];
  endfunction

  // Writes may only target read-write indices; reads any existing index.
  function automatic logic index_ok(input logic wr, input logic [ADDR_W-1:0] a,
                                    input int n_rw, input int n_all);
    if (wr) return int'(a) < n_rw;
    return int'(a) < n_all;
  endfunction
endpackage

// File: rtl/spi_msg_ctrl.sv
module spi_msg_ctrl
  import spi_msg_pkg::*;
#(
  parameter int N_RW = 4,
  parameter int N_RO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output msg_state_e        state_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              ev_cmd_o,
  output logic              ev_snap_o,
  output logic              ev_shift_o,
  output logic              ev_commit_o,
  output logic              ev_send_o,
  output logic [BIDX_W-1:0] send_idx_o,
  output logic [7:0]        stat_byte_o
);
  localparam int N_ALL = N_RW + N_RO;
  localparam logic [BIDX_W-1:0] TOP_IDX = BIDX_W'(WORD_BYTES - 1);

  msg_state_e        state_q;
  logic [BIDX_W-1:0] idx_q;
  logic              wr_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic              take, cmd_err;

  assign take    = sel_i && rx_valid_i;
  assign cmd_err = !index_ok(rx_byte_i[7], rx_byte_i[6:0], N_RW, N_ALL);

  always_comb begin
    ev_cmd_o    = take && state_q == ST_IDLE;
    ev_snap_o   = take && state_q == ST_TX_STAT && !wr_q;
    ev_shift_o  = take && state_q == ST_RX_WORD;
    ev_commit_o = ev_shift_o && idx_q == '0 && !err_q;
    ev_send_o   = ev_snap_o || (take && state_q == ST_TX_WORD && idx_q != '0);
    send_idx_o  = ev_snap_o ? TOP_IDX : idx_q - BIDX_W'(1);
    stat_byte_o = status_byte(rx_byte_i[7], cmd_err);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
    end else if (!sel_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (rx_valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          wr_q    <= rx_byte_i[7];
          addr_q  <= rx_byte_i[6:0];
          err_q   <= cmd_err;
          idx_q   <= '0;
          state_q <= ST_TX_STAT;
        end
        ST_TX_STAT: begin
          idx_q   <= TOP_IDX;
          state_q <= wr_q ? ST_RX_WORD : ST_TX_WORD;
        end
        ST_TX_WORD, ST_RX_WORD: begin
          if (idx_q == '0) state_q <= ST_IDLE;
          else             idx_q   <= idx_q - BIDX_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign cmd_addr_o = addr_q;
endmodule

// File: rtl/spi_msg_regs.sv
module spi_msg_regs
  import spi_msg_pkg::*;
#(
  parameter int N_RW = 4,
  parameter int N_RO = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [WORD_W-1:0]      wr_data_i,
  input  logic [N_RO*WORD_W-1:0] ro_flat_i,
  output logic [N_RW*WORD_W-1:0] rw_flat_o,
  output logic [WORD_W-1:0]      rd_data_o
);
  localparam int N_ALL = N_RW + N_RO;

  logic [WORD_W-1:0] bank [N_ALL];

  for (genvar g = 0; g < N_RW; g++) begin : g_rw
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   q <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(g))     q <= wr_data_i;
    end
    assign rw_flat_o[g*WORD_W +: WORD_W] = q;
    assign bank[g] = q;
  end

  for (genvar g = 0; g < N_RO; g++) begin : g_ro
    assign bank[N_RW+g] = ro_flat_i[g*WORD_W +: WORD_W];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_ALL; i++)
      if (addr_i == ADDR_W'(i)) rd_data_o = bank[i];
  end
endmodule

// File: rtl/spi_msg_data.sv
module spi_msg_data
  import spi_msg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              shift_i,
  input  logic              snap_i,
  input  logic [7:0]        rx_byte_i,
  input  logic [WORD_W-1:0] rd_data_i,
  input  logic [BIDX_W-1:0] send_idx_i,
  output logic [WORD_W-1:0] wr_word_o,
  output logic [7:0]        send_byte_o
);
  logic [WORD_W-9:0] asm_q;
  logic [WORD_W-1:0] snap_q;

  assign wr_word_o   = {asm_q, rx_byte_i};
  assign send_byte_o = pick_byte(snap_i ? rd_data_i : snap_q, send_idx_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_q  <= '0;
      snap_q <= '0;
    end else begin
      if (!sel_i)       asm_q <= '0;
      else if (shift_i) asm_q <= wr_word_o[WORD_W-9:0];
      if (snap_i)       snap_q <= rd_data_i;
    end
  end
endmodule

// File: rtl/spi_msg_regbank.sv
module spi_msg_regbank
  import spi_msg_pkg::*;
#(
  parameter int N_RW = 4,
  parameter int N_RO = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_i,
  input  logic                   rx_valid_i,
  input  logic [7:0]             rx_byte_i,
  output logic                   tx_load_o,
  output logic [7:0]             tx_byte_o,
  output logic [1:0]             msg_state_o,
  output logic [N_RW*WORD_W-1:0] rw_regs_o,
  input  logic [N_RO*WORD_W-1:0] ro_regs_i
);
  msg_state_e        state;
  logic [ADDR_W-1:0] cmd_addr;
  logic              ev_cmd, ev_snap, ev_shift, ev_commit, ev_send;
  logic [BIDX_W-1:0] send_idx;
  logic [7:0]        stat_byte, send_byte;
  logic [WORD_W-1:0] wr_word, rd_data;
  logic              load_q;
  logic [7:0]        byte_q;

  spi_msg_ctrl #(.N_RW(N_RW), .N_RO(N_RO)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rx_valid_i(rx_valid_i),
    .rx_byte_i(rx_byte_i), .state_o(state), .cmd_addr_o(cmd_addr),
    .ev_cmd_o(ev_cmd), .ev_snap_o(ev_snap), .ev_shift_o(ev_shift),
    .ev_commit_o(ev_commit), .ev_send_o(ev_send), .send_idx_o(send_idx),
    .stat_byte_o(stat_byte)
  );

  spi_msg_regs #(.N_RW(N_RW), .N_RO(N_RO)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(ev_commit), .addr_i(cmd_addr),
    .wr_data_i(wr_word), .ro_flat_i(ro_regs_i), .rw_flat_o(rw_regs_o),
    .rd_data_o(rd_data)
  );

  spi_msg_data u_data (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .shift_i(ev_shift),
    .snap_i(ev_snap), .rx_byte_i(rx_byte_i), .rd_data_i(rd_data),
    .send_idx_i(send_idx), .wr_word_o(wr_word), .send_byte_o(send_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      byte_q <= '0;
    end else begin
      load_q <= ev_cmd || ev_send;
      if (ev_cmd)       byte_q <= stat_byte;
      else if (ev_send) byte_q <= send_byte;
    end
  end

  assign tx_load_o   = load_q;
  assign tx_byte_o   = byte_q;
  assign msg_state_o = state;
endmodule

// File: rtl/spi_msg_regbank_chk.sv
module spi_msg_regbank_chk #(
  parameter int N_RW = 4,
  parameter int N_RO = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sel_i,
  input logic                rx_valid_i,
  input logic                tx_load_o,
  input logic [7:0]          tx_byte_o,
  input logic [1:0]          state,
  input logic [1:0]          byte_idx,
  input logic                ev_commit,
  input logic [6:0]          cmd_addr,
  input logic [N_RW*32-1:0]  rw_regs_o
);
  p_status_follows_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && rx_valid_i && state == 2'd0) |=> (tx_load_o && tx_byte_o[7:4] == 4'hA));

  p_hold_until_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_commit |=> $stable(rw_regs_o));

  p_no_load_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && rx_valid_i && state == 2'd3) |=> !tx_load_o);

  p_commit_rw_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |-> (int'(cmd_addr) < N_RW));

  p_desel_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> (state == 2'd0 && byte_idx == 2'd0));

  p_desel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !tx_load_o);

  p_idle_idx_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> (byte_idx == 2'd0));
endmodule

bind spi_msg_regbank spi_msg_regbank_chk #(.N_RW(N_RW), .N_RO(N_RO)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rx_valid_i(rx_valid_i),
  .tx_load_o(tx_load_o), .tx_byte_o(tx_byte_o), .state(msg_state_o),
  .byte_idx(u_ctrl.idx_q), .ev_commit(ev_commit), .cmd_addr(cmd_addr),
  .rw_regs_o(rw_regs_o)
);

// File: tb/spi_msg_regbank_tb.sv
module spi_msg_regbank_tb;
  localparam int N_RW = 4;
  localparam int N_RO = 2;
  localparam int W    = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, sel, rxv;
  logic [7:0]        rxb;
  logic              txl;
  logic [7:0]        txb;
  logic [1:0]        st;
  logic [N_RW*W-1:0] rw;
  logic [N_RO*W-1:0] ro;

  spi_msg_regbank #(.N_RW(N_RW), .N_RO(N_RO)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .rx_valid_i(rxv), .rx_byte_i(rxb),
    .tx_load_o(txl), .tx_byte_o(txb), .msg_state_o(st),
    .rw_regs_o(rw), .ro_regs_i(ro)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [31:0] model [N_RW];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input bit wr, input bit err);
    logic [7:0] s;
    s = 8'b1010_0000;
    s[1] = wr;
    s[0] = err;
    return s;
  endfunction

  task automatic expect_byte(input logic [7:0] b, input string req);
    exp_q.push_back(b);
    tag_q.push_back(req);
  endtask

  task automatic expect_word(input logic [31:0] w, input string req);
    for (int k = 3; k >= 0; k--) expect_byte(w[8*k +: 8], req);
  endtask

  // Scoreboard monitor: every load must match the head of the queue.
  always @(negedge clk) begin
    if (rst_n && txl) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected load", {24'b0, txb}, 32'h0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(txb == e, t, {24'b0, txb}, {24'b0, e});
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); rxv = 1'b1; rxb = b;
    @(negedge clk); rxv = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_bank(input string req);
    for (int n = 0; n < N_RW; n++) chk(rw[n*W +: W] == model[n], req, rw[n*W +: W], model[n]);
  endtask

  task automatic do_read(input logic [6:0] a, input logic [31:0] w, input bit err);
    expect_byte(stat(1'b0, err), "R2 read status");
    expect_word(w, err ? "R6 oob read data" : "R3 read data");
    send({1'b0, a});
    chk(st == 2'd1, "R10 state after cmd", {30'b0, st}, 32'd1);
    send(8'h00);
    chk(st == 2'd2, "R10 state in read", {30'b0, st}, 32'd2);
    for (int k = 0; k < 4; k++) send(8'h00);
    chk(st == 2'd0, "R3 idle after word", {30'b0, st}, 32'd0);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] w, input bit err);
    expect_byte(stat(1'b1, err), err ? "R6 write status" : "R2 write status");
    send({1'b1, a});
    send(8'h00);
    chk(st == 2'd3, "R10 state in write", {30'b0, st}, 32'd3);
    for (int k = 3; k >= 1; k--) send(w[8*k +: 8]);
    check_bank("R5 no early commit");
    send(w[7:0]);
    if (!err) model[a] = w;
    check_bank(err ? "R6 dropped write" : "R5 R9 committed word");
    chk(st == 2'd0, "R5 idle after write", {30'b0, st}, 32'd0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; rxv = 1'b0; rxb = '0;
    ro = {32'h5A5A_0102, 32'hC0FF_EE11};
    for (int n = 0; n < N_RW; n++) model[n] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(st == 2'd0, "R1 state", {30'b0, st}, 32'd0);
    chk(txl == 1'b0, "R1 load", {31'b0, txl}, 32'd0);
    chk(rw == '0, "R1 registers", {31'b0, |rw}, 32'd0);

    sel = 1'b1;
    do_write(7'd1, 32'hDEAD_BEEF, 1'b0);
    do_read(7'd1, 32'hDEAD_BEEF, 1'b0);
    do_write(7'd0, 32'h0123_4567, 1'b0);
    do_write(7'd3, 32'h89AB_CDEF, 1'b0);
    do_read(7'd3, 32'h89AB_CDEF, 1'b0);
    chk(rw[3*W +: W] == 32'h89AB_CDEF, "R9 slice of reg3", rw[3*W +: W], 32'h89AB_CDEF);

    // R4 snapshot: ro slot 1 is index N_RW+1
    expect_byte(stat(1'b0, 1'b0), "R2 ro status");
    expect_word(32'h5A5A_0102, "R4 snapshot word");
    send({1'b0, 7'(N_RW + 1)});
    send(8'h00);
    ro[1*W +: W] = 32'h1234_5678;
    for (int k = 0; k < 4; k++) send(8'h00);
    do_read(7'(N_RW + 1), 32'h1234_5678, 1'b0);
    do_read(7'(N_RW), 32'hC0FF_EE11, 1'b0);

    // R6 illegal targets
    do_write(7'(N_RW), 32'hFFFF_FFFF, 1'b1);
    do_read(7'(N_RW), 32'hC0FF_EE11, 1'b0);
    do_write(7'd100, 32'h5555_AAAA, 1'b1);
    do_read(7'd100, 32'h0, 1'b1);

    // R7 abort a write after two data bytes
    expect_byte(stat(1'b1, 1'b0), "R7 write status");
    send({1'b1, 7'd2});
    send(8'h00);
    send(8'h77);
    send(8'h66);
    sel = 1'b0;
    @(negedge clk);
    chk(st == 2'd0, "R7 idle on deselect", {30'b0, st}, 32'd0);
    check_bank("R7 partial write discarded");
    sel = 1'b1;
    do_read(7'd2, 32'h0, 1'b0);

    // R8 strobes while deselected
    sel = 1'b0;
    send(8'h81);
    send(8'h02);
    chk(st == 2'd0, "R8 no state change", {30'b0, st}, 32'd0);
    check_bank("R8 no register change");
    sel = 1'b1;
    do_read(7'd0, 32'h0123_4567, 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected bytes sent", exp_q.size(), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule